// File: doc/BRIEF.md
# Memory Module Configuration Store Two-Wire Target

This block is the target side of a two-wire (SMBus/I2C) link that stands in for the small configuration memory carried on a memory module. A host reads module timing and identity data from it at boot. Three strap inputs give the slot number, so up to eight modules can share one clock line and one data line. The data line is open drain. The block only pulls it low, and it never stretches the clock.

One target answers three address groups, all offset by the same strap value. The first is a 256-byte storage region. The second is a protect group that locks the storage against writes. The third is an optional thermal group that returns a 16-bit reading taken from an input port. The storage works in the usual way. In a write, the first data byte loads an 8-bit word pointer and each later data byte is stored. A read returns bytes in sequence and steps the pointer after each one. Once the lock is set, the protect group stops answering, and data written to the storage is acknowledged but thrown away. Reset reloads the storage from a computed image and clears the lock.

The control line (SCL) and data line (SDA) are oversampled in the system clock domain through a two-stage synchronizer. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high.

Top module: `spd_target`

## Requirements
- R1: Address 0x50 + strap (7-bit) is acknowledged in both directions and selects the 256-byte storage.
- R2: While the lock is clear, address 0x30 + strap is acknowledged. A read there returns 0xFF.
- R3: With the thermal group enabled, address 0x18 + strap is acknowledged. A read returns temp_i[15:8] first, then temp_i[7:0], alternating for as long as the host keeps acknowledging. Writes there are acknowledged and ignored.
- R4: Any other address gets a NACK, and sda_oe stays low until the next START.
- R5: In a storage write, the first data byte sets the word pointer. Each later byte is stored at the pointer, which then increments. Every data byte is acknowledged.
- R6: A storage read returns the byte at the pointer and then increments it. The pointer wraps from 0xFF to 0x00.
- R7: A write-direction address to 0x30 + strap sets a lock that only reset clears. While the lock is set, 0x30 + strap gets a NACK, and storage data bytes are acknowledged but not stored (the pointer still advances).
- R8: While transmitting, the target changes sda_oe only while SCL is low.
- R9: When the host NACKs a read byte, the target drives nothing more until START or STOP.
- R10: While rst_n is low, sda_oe is low, the lock clears, and byte i of the storage is loaded with (i*IMG_MUL + IMG_ADD) mod 256.
- R11: A repeated START keeps the word pointer, so a pointer write followed by a repeated-START read returns data from that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Slot strap value added to each group base |
| temp_i | input | 16 | Thermal reading returned by the thermal group |
| sda_oe | output | 1 | High pulls the data line low |

## Verification
The bench builds the block with its default parameters: a 256-byte storage, the thermal group enabled, and the image multiplier 7 with offset 3. Because the multiplier is odd, every byte of the reset image is distinct, so a wrong pointer or a missed wrap shows up as a wrong value. At strap 3 the bench probes all 128 addresses. For each of the other strap values it probes every group plus a neighbouring address. One unbroken 257-byte read covers the whole storage and the wrap. The storage is small enough that this read can be exhaustive.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_WACK, ST_TX, ST_MACK, ST_SKIP
  } spd_state_e;

  typedef enum logic [1:0] {
    GRP_NONE, GRP_MEM, GRP_LOCK, GRP_TEMP
  } spd_grp_e;
endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_i,
  output logic [WIDTH-1:0] now_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '1;
          else        stage_q[g] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '1;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign now_o  = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/spd_addr_match.sv
module spd_addr_match
  import spd_pkg::*;
#(
  parameter logic [6:0] MEM_BASE  = 7'h50,
  parameter logic [6:0] LOCK_BASE = 7'h30,
  parameter logic [6:0] TEMP_BASE = 7'h18,
  parameter bit         TEMP_EN   = 1'b1
) (
  input  logic [6:0] addr_i,
  input  logic [2:0] strap_i,
  input  logic       lock_i,
  output logic       hit_o,
  output spd_grp_e   grp_o
);
  logic mem_hit, lock_hit, temp_hit;

  assign mem_hit  = (addr_i[6:3] == MEM_BASE[6:3])  && (addr_i[2:0] == strap_i);
  assign lock_hit = (addr_i[6:3] == LOCK_BASE[6:3]) && (addr_i[2:0] == strap_i) && !lock_i;

  generate
    if (TEMP_EN) begin : g_temp
      assign temp_hit = (addr_i[6:3] == TEMP_BASE[6:3]) && (addr_i[2:0] == strap_i);
    end else begin : g_no_temp
      assign temp_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    grp_o = GRP_NONE;
    if (mem_hit)       grp_o = GRP_MEM;
    else if (lock_hit) grp_o = GRP_LOCK;
    else if (temp_hit) grp_o = GRP_TEMP;
  end

  assign hit_o = (grp_o != GRP_NONE);
endmodule

// File: rtl/spd_store.sv
module spd_store #(
  parameter int         PTR_W   = 8,
  parameter logic [7:0] IMG_MUL = 8'd7,
  parameter logic [7:0] IMG_ADD = 8'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  localparam int DEPTH = 1 << PTR_W;

  logic [7:0] cell_q [DEPTH];

  function automatic logic [7:0] image_byte(input int idx);
    logic [15:0] prod;
    prod = 16'(idx) * 16'(IMG_MUL) + 16'(IMG_ADD);
    return prod[7:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= image_byte(i);
    end else if (we_i) begin
      cell_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = cell_q[raddr_i];
endmodule

// File: rtl/spd_target.sv
module spd_target
  import spd_pkg::*;
#(
  parameter int         PTR_W     = 8,
  parameter int         SYNC_LEN  = 2,
  parameter logic [6:0] MEM_BASE  = 7'h50,
  parameter logic [6:0] LOCK_BASE = 7'h30,
  parameter logic [6:0] TEMP_BASE = 7'h18,
  parameter bit         TEMP_EN   = 1'b1,
  parameter logic [7:0] IMG_MUL   = 8'd7,
  parameter logic [7:0] IMG_ADD   = 8'd3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  strap_i,
  input  logic [15:0] temp_i,
  output logic        sda_oe
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

  logic [1:0] line_now, line_prev;
  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, bus_start, bus_stop;

  spd_line_sync #(.WIDTH(2), .STAGES(SYNC_LEN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i ({scl_i, sda_i}),
    .now_o  (line_now),
    .prev_o (line_prev)
  );

  assign {scl_s, sda_s} = line_now;
  assign {scl_p, sda_p} = line_prev;
  assign scl_rise  =  scl_s && !scl_p;
  assign scl_fall  = !scl_s &&  scl_p;
  assign bus_start =  scl_s &&  scl_p &&  sda_p && !sda_s;
  assign bus_stop  =  scl_s &&  scl_p && !sda_p &&  sda_s;

  spd_state_e       state_q, state_d;
  spd_grp_e         grp_q, grp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       rx_q, rx_d;
  logic [7:0]       tx_q, tx_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             wp_q, wp_d;
  logic             first_q, first_d;
  logic             rw_q, rw_d;
  logic             tsel_q, tsel_d;
  logic             oe_q, oe_d;
  logic             hack_q, hack_d;

  logic             hit;
  spd_grp_e         hit_grp;
  logic [7:0]       mem_rdata;
  logic [7:0]       rd_byte;
  logic             mem_we;

  spd_addr_match #(
    .MEM_BASE  (MEM_BASE),
    .LOCK_BASE (LOCK_BASE),
    .TEMP_BASE (TEMP_BASE),
    .TEMP_EN   (TEMP_EN)
  ) u_match (
    .addr_i  (rx_q[7:1]),
    .strap_i (strap_i),
    .lock_i  (wp_q),
    .hit_o   (hit),
    .grp_o   (hit_grp)
  );

  spd_store #(
    .PTR_W   (PTR_W),
    .IMG_MUL (IMG_MUL),
    .IMG_ADD (IMG_ADD)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mem_we),
    .waddr_i (ptr_q),
    .wdata_i (rx_q),
    .raddr_i (ptr_q),
    .rdata_o (mem_rdata)
  );

  always_comb begin
    case (grp_q)
      GRP_MEM:  rd_byte = mem_rdata;
      GRP_TEMP: rd_byte = tsel_q ? temp_i[7:0] : temp_i[15:8];
      default:  rd_byte = 8'hFF;
    endcase
  end

  always_comb begin
    state_d = state_q;
    grp_d   = grp_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    wp_d    = wp_q;
    first_d = first_q;
    rw_d    = rw_q;
    tsel_d  = tsel_q;
    oe_d    = oe_q;
    hack_d  = hack_q;
    mem_we  = 1'b0;

    if (bus_start) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      first_d = 1'b1;
    end else if (bus_stop) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_d  = {rx_q[6:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == BYTE_BITS) begin
            if (hit) begin
              grp_d   = hit_grp;
              rw_d    = rx_q[0];
              tsel_d  = 1'b0;
              oe_d    = 1'b1;
              state_d = ST_AACK;
              if (hit_grp == GRP_LOCK && !rx_q[0]) wp_d = 1'b1;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_SKIP;
            end
          end
        end
        ST_AACK, ST_MACK: begin
          if (state_q == ST_MACK && scl_rise) begin
            hack_d = !sda_s;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (state_q == ST_AACK && !rw_q) begin
              oe_d    = 1'b0;
              state_d = ST_RX;
            end else if (state_q == ST_MACK && !hack_q) begin
              oe_d    = 1'b0;
              state_d = ST_SKIP;
            end else begin
              tx_d    = rd_byte;
              oe_d    = !rd_byte[7];
              state_d = ST_TX;
              if (grp_q == GRP_MEM)  ptr_d  = ptr_q + 1'b1;
              if (grp_q == GRP_TEMP) tsel_d = !tsel_q;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            rx_d  = {rx_q[6:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == BYTE_BITS) begin
            if (grp_q == GRP_MEM) begin
              if (first_q) begin
                ptr_d = rx_q[PTR_W-1:0];
              end else begin
                mem_we = !wp_q;
                ptr_d  = ptr_q + 1'b1;
              end
            end
            first_d = 1'b0;
            oe_d    = 1'b1;
            state_d = ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == BYTE_BITS) begin
              oe_d    = 1'b0;
              state_d = ST_MACK;
            end else begin
              tx_d = {tx_q[6:0], 1'b0};
              oe_d = !tx_q[6];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grp_q   <= GRP_NONE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      wp_q    <= 1'b0;
      first_q <= 1'b1;
      rw_q    <= 1'b0;
      tsel_q  <= 1'b0;
      oe_q    <= 1'b0;
      hack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      grp_q   <= grp_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      wp_q    <= wp_d;
      first_q <= first_d;
      rw_q    <= rw_d;
      tsel_q  <= tsel_d;
      oe_q    <= oe_d;
      hack_q  <= hack_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/spd_target_chk.sv
module spd_target_chk
  import spd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       wp,
  input spd_state_e state
);
  // R8: while a byte is being sent, the drive level holds across SCL high
  a_r8_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && state == ST_TX && $past(state) == ST_TX) |-> $stable(sda_oe));

  // R7: the lock is sticky until reset
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wp) |-> wp);

  // R4, R9: a dismissed transaction never drives the line
  a_r4_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_oe);

  // R10: idle after STOP or reset leaves the line released
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R10: released during reset
  always @(posedge clk) begin
    if (!rst_n) a_r10_reset_quiet: assert (!sda_oe);
  end
endmodule

bind spd_target spd_target_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_i  (scl_i),
  .sda_oe (sda_oe),
  .wp     (wp_q),
  .state  (state_q)
);

// File: tb/test_spd_target.sv
module test_spd_target;
  logic        clk;
  logic        rst_n;
  logic        scl;
  logic        m_low;
  logic [2:0]  strap;
  logic [15:0] temp;
  logic        sda_oe;
  logic        sda_bus;

  int checks;
  int errors;
  int r8_viol;
  logic oe_seen;
  logic scl_d;
  logic oe_d;

  localparam logic [15:0] TEMP_VAL = 16'hA53C;

  assign sda_bus = !(m_low || sda_oe);

  spd_target i_spd_target (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_bus),
    .strap_i (strap),
    .temp_i  (temp),
    .sda_oe  (sda_oe)
  );

  initial clk = 1'b0;
  always #4 clk = !clk;

  always @(posedge clk) begin
    if (rst_n && scl && scl_d && (sda_oe != oe_d)) r8_viol++;
    if (sda_oe) oe_seen = 1'b1;
    scl_d <= scl;
    oe_d  <= sda_oe;
  end

  function automatic logic [7:0] img(input int i);
    return 8'((i % 256) * 7 + 3);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_bit(input bit b, output bit r);
    m_low = !b;
    hp();
    scl = 1'b1;
    repeat (5) @(negedge clk);
    r = sda_bus;
    repeat (5) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic bus_start();
    m_low = 1'b0;
    hp();
    scl = 1'b1;
    hp();
    m_low = 1'b1;
    hp();
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_low = 1'b1;
    hp();
    scl = 1'b1;
    hp();
    m_low = 1'b0;
    hp();
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
    bus_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] v);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      v[i] = r;
    end
    bus_bit(!give_ack, r);
  endtask

  task automatic probe(input logic [6:0] a, input bit rw, output bit ack);
    bus_start();
    wr_byte({a, rw}, ack);
    bus_stop();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic run_all();
    bit ack;
    logic [7:0] v;
    logic [6:0] a;
    do_reset();
    check(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);

    // R1 R2 R3 R4 per strap
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      probe(7'h50 + 7'(s), 1'b0, ack);
      check(ack, "R1 storage address", ack, 1);
      probe(7'h30 + 7'(s), 1'b1, ack);
      check(ack, "R2 lock group address", ack, 1);
      probe(7'h18 + 7'(s), 1'b0, ack);
      check(ack, "R3 thermal group address", ack, 1);
      probe(7'h50 + 7'((s + 1) % 8), 1'b0, ack);
      check(!ack, "R4 neighbour slot", ack, 0);
    end

    // full address sweep at strap 3
    strap = 3'd3;
    for (int i = 0; i < 128; i++) begin
      bit exp;
      a   = 7'(i);
      exp = (a == 7'h53) || (a == 7'h33) || (a == 7'h1B);
      probe(a, (a == 7'h33), ack);
      check(ack == exp, "R4 address sweep", {a, ack}, {a, exp});
    end

    // R5 R11 R6: pointer write, repeated START, full read with wrap
    bus_start();
    wr_byte({7'h53, 1'b0}, ack);
    wr_byte(8'h00, ack);
    check(ack, "R5 pointer byte acked", ack, 1);
    bus_start();
    wr_byte({7'h53, 1'b1}, ack);
    for (int i = 0; i < 257; i++) begin
      rd_byte(i != 256, v);
      check(v == img(i), "R6 R11 sequential read", v, img(i));
    end
    bus_stop();

    // R5 write across the wrap, read back
    bus_start();
    wr_byte({7'h53, 1'b0}, ack);
    wr_byte(8'hFE, ack);
    wr_byte(8'h11, ack);
    wr_byte(8'h22, ack);
    wr_byte(8'h33, ack);
    check(ack, "R5 data byte acked", ack, 1);
    bus_stop();
    bus_start();
    wr_byte({7'h53, 1'b0}, ack);
    wr_byte(8'hFD, ack);
    bus_start();
    wr_byte({7'h53, 1'b1}, ack);
    rd_byte(1'b1, v); check(v == img(8'hFD), "R5 readback FD", v, img(8'hFD));
    rd_byte(1'b1, v); check(v == 8'h11, "R5 readback FE", v, 8'h11);
    rd_byte(1'b1, v); check(v == 8'h22, "R5 readback FF", v, 8'h22);
    rd_byte(1'b1, v); check(v == 8'h33, "R5 readback 00 after wrap", v, 8'h33);
    rd_byte(1'b0, v); check(v == img(1), "R6 readback 01", v, img(1));
    bus_stop();

    // R3 thermal read, both bytes then alternation
    bus_start();
    wr_byte({7'h1B, 1'b1}, ack);
    rd_byte(1'b1, v); check(v == TEMP_VAL[15:8], "R3 thermal high", v, TEMP_VAL[15:8]);
    rd_byte(1'b1, v); check(v == TEMP_VAL[7:0], "R3 thermal low", v, TEMP_VAL[7:0]);
    rd_byte(1'b0, v); check(v == TEMP_VAL[15:8], "R3 thermal repeat", v, TEMP_VAL[15:8]);
    bus_stop();

    // R2 lock group read value
    bus_start();
    wr_byte({7'h33, 1'b1}, ack);
    rd_byte(1'b0, v);
    check(v == 8'hFF, "R2 lock group read", v, 8'hFF);
    bus_stop();

    // R9 host NACK ends transmission
    bus_start();
    wr_byte({7'h53, 1'b0}, ack);
    wr_byte(8'h80, ack);
    bus_start();
    wr_byte({7'h53, 1'b1}, ack);
    rd_byte(1'b0, v);
    check(v == img(8'h80), "R9 byte before NACK", v, img(8'h80));
    @(negedge clk);
    oe_seen = 1'b0;
    rd_byte(1'b0, v);
    check(!oe_seen && v == 8'hFF, "R9 silent after NACK", {oe_seen, v}, 9'h0FF);
    bus_stop();

    // R4 released after address NACK
    bus_start();
    wr_byte({7'h60, 1'b0}, ack);
    check(!ack, "R4 foreign address", ack, 0);
    @(negedge clk);
    oe_seen = 1'b0;
    wr_byte(8'h00, ack);
    check(!oe_seen && !ack, "R4 silent until START", {oe_seen, ack}, 0);
    bus_stop();

    // R7 lock
    probe(7'h33, 1'b0, ack);
    check(ack, "R7 lock write acked", ack, 1);
    probe(7'h33, 1'b0, ack);
    check(!ack, "R7 lock group NACKed (write)", ack, 0);
    probe(7'h33, 1'b1, ack);
    check(!ack, "R7 lock group NACKed (read)", ack, 0);
    bus_start();
    wr_byte({7'h53, 1'b0}, ack);
    wr_byte(8'h10, ack);
    wr_byte(8'h99, ack);
    check(ack, "R7 locked data acked", ack, 1);
    wr_byte(8'h98, ack);
    bus_start();
    wr_byte({7'h53, 1'b1}, ack);
    rd_byte(1'b1, v);
    check(v == img(8'h12), "R7 pointer advanced while locked", v, img(8'h12));
    rd_byte(1'b0, v);
    bus_stop();
    bus_start();
    wr_byte({7'h53, 1'b0}, ack);
    wr_byte(8'h10, ack);
    bus_start();
    wr_byte({7'h53, 1'b1}, ack);
    rd_byte(1'b0, v);
    check(v == img(8'h10), "R7 locked data discarded", v, img(8'h10));
    bus_stop();

    // R10 reset clears lock and reloads storage
    do_reset();
    probe(7'h33, 1'b1, ack);
    check(ack, "R10 lock cleared", ack, 1);
    bus_start();
    wr_byte({7'h53, 1'b0}, ack);
    wr_byte(8'hFE, ack);
    bus_start();
    wr_byte({7'h53, 1'b1}, ack);
    rd_byte(1'b1, v); check(v == img(8'hFE), "R10 image reload FE", v, img(8'hFE));
    rd_byte(1'b0, v); check(v == img(8'hFF), "R10 image reload FF", v, img(8'hFF));
    bus_stop();

    check(r8_viol == 0, "R8 drive changes only with SCL low", r8_viol, 0);
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    r8_viol = 0;
    oe_seen = 1'b0;
    scl_d   = 1'b1;
    oe_d    = 1'b0;
    rst_n   = 1'b0;
    scl     = 1'b1;
    m_low   = 1'b0;
    strap   = 3'd0;
    temp    = TEMP_VAL;
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule